// File: doc/BRIEF.md
# Program and Erase Status Reporter

This block forms the word a host reads back from a flash array while a program or erase runs inside the part. It keeps a copy of the last word loaded and the kind of the operation, and a busy flag from the operation timer. On each qualified read strobe it captures a response word. While busy, that word carries two completion indicators on every byte lane. One is a polling bit that reads as the inverse of the loaded data during a program and as zero during an erase. The other is a toggle bit that flips on every read. When busy is low, the response is the array data presented on the read.

The response register holds its value between strobes. The output pins are driven only while chip enable and output enable are both low. When either is high the drive enable is low and the data outputs are zero, which models a high-impedance bus. A start pulse from the command logic records the new operation and clears the toggle state. Array storage and command decoding sit outside this block.

Top module: `flash_status_reporter`

## Requirements
- R1: When `ce_n` or `oe_n` is high, `dq_en` is 0 and `dq_out` is 0. When both are low, `dq_en` is 1 and `dq_out` shows the held response, which is kept unchanged across the masked period.
- R2: A read strobe during busy for a program operation (`op_erase`=0) returns, in bit 7 and bit 15, the inverse of bit 7 and bit 15 of the loaded word.
- R3: A read strobe during busy for an erase operation (`op_erase`=1) returns 0 in bit 7 and bit 15.
- R4: Each read strobe during busy returns the current toggle value in bit 6 and bit 14, with both lanes equal, and then inverts that value for the next read.
- R5: The toggle value changes only on a read strobe taken while busy. Idle cycles and reads while busy is low leave it unchanged.
- R6: A read strobe during busy returns 0 in every bit other than 15, 14, 7 and 6.
- R7: A read strobe while busy is low returns `array_data` as sampled on that strobe.
- R8: An `op_start` pulse clears the toggle value, so the first busy read of an operation shows 0 in bits 6 and 14.
- R9: When `op_start` and a busy read strobe fall in the same cycle, the read reflects the new operation's word, its kind and a toggle value of 0, and the next busy read shows toggle 1.
- R10: After synchronous reset the response is 0x0000, the toggle value is 0, and the held operation is a program of word 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse when a new program or erase begins |
| op_erase | input | 1 | Kind of the starting operation: 1 erase, 0 program |
| op_word | input | 16 | Word loaded with the starting operation |
| busy | input | 1 | High while the internal operation runs |
| rd_strobe | input | 1 | One-cycle qualified read access |
| array_data | input | 16 | True array data for the current read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_out | output | 16 | Read data (0 when not driven) |
| dq_en | output | 1 | Output drive enable |

## Verification
An operation start and a read strobe can land in the same clock cycle. In that case the start must take priority: the read reports the new word and kind with a cleared toggle, and the toggle still advances. The bench provokes this with a directed erase whose start is paired with a read. Its random phase also pairs starts with reads by chance. Each response is compared with a bench model that applies the start before the read, and the toggle phase of the next busy read is compared as well.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
    parameter int LANES    = 2;
    parameter int LANE_W   = 8;
    parameter int POLL_POS = 7;
    parameter int TOG_POS  = 6;
    localparam int WORD_W  = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        word_t    word;
    } op_ctx_t;

    // Bits that carry completion indicators during busy.
    function automatic word_t status_mask();
        word_t m;
        m = '0;
        for (int l = 0; l < LANES; l++) begin
            m[l*LANE_W + POLL_POS] = 1'b1;
            m[l*LANE_W + TOG_POS]  = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/fsr_op_latch.sv
`timescale 1ns/1ps
module fsr_op_latch
    import fsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  op_ctx_t start_ctx,
    output op_ctx_t eff_ctx
);
    op_ctx_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q.kind <= OP_PROGRAM;
            held_q.word <= '0;
        end else if (start) begin
            held_q <= start_ctx;
        end
    end

    // A starting operation is visible in its own cycle.
    always_comb eff_ctx = start ? start_ctx : held_q;

    a_r10_ctx_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> held_q == $past(held_q));
endmodule

// File: rtl/fsr_toggle.sv
`timescale 1ns/1ps
module fsr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic advance,
    output logic eff_tog
);
    logic tog_q;

    always_comb eff_tog = start ? 1'b0 : tog_q;

    always_ff @(posedge clk) begin
        if (rst)          tog_q <= 1'b0;
        else if (advance) tog_q <= ~eff_tog;
        else              tog_q <= eff_tog;
    end

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!start && !advance) |=> tog_q == $past(tog_q));
    a_r4_flip: assert property (@(posedge clk) disable iff (rst)
        (!start && advance) |=> tog_q != $past(tog_q));
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        (start && !advance) |=> tog_q == 1'b0);
    a_r9_start_read: assert property (@(posedge clk) disable iff (rst)
        (start && advance) |=> tog_q == 1'b1);
endmodule

// File: rtl/fsr_resp.sv
`timescale 1ns/1ps
module fsr_resp
    import fsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd,
    input  logic    busy,
    input  op_ctx_t eff_ctx,
    input  logic    eff_tog,
    input  word_t   array_data,
    output word_t   resp_q
);
    word_t busy_word;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int BASE = l * LANE_W;
        for (genvar b = 0; b < LANE_W; b++) begin : g_bit
            if (b == POLL_POS) begin : g_poll
                always_comb busy_word[BASE+b] =
                    (eff_ctx.kind == OP_PROGRAM) ? ~eff_ctx.word[BASE+b] : 1'b0;
            end else if (b == TOG_POS) begin : g_tog
                always_comb busy_word[BASE+b] = eff_tog;
            end else begin : g_zero
                always_comb busy_word[BASE+b] = 1'b0;
            end
        end

        a_r4_lanes_equal: assert property (@(posedge clk) disable iff (rst)
            (rd && busy) |=> resp_q[BASE+TOG_POS] == resp_q[TOG_POS]);
        a_r3_erase_zero: assert property (@(posedge clk) disable iff (rst)
            (rd && busy && eff_ctx.kind == OP_ERASE) |=> resp_q[BASE+POLL_POS] == 1'b0);
    end

    always_ff @(posedge clk) begin
        if (rst)     resp_q <= '0;
        else if (rd) resp_q <= busy ? busy_word : array_data;
    end

    a_r7_pass: assert property (@(posedge clk) disable iff (rst)
        (rd && !busy) |=> resp_q == $past(array_data));
    a_r6_quiet_bits: assert property (@(posedge clk) disable iff (rst)
        (rd && busy) |=> (resp_q & ~status_mask()) == '0);
    a_r1_hold_resp: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(resp_q));
endmodule

// File: rtl/flash_status_reporter.sv
`timescale 1ns/1ps
module flash_status_reporter
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_start,
    input  logic              op_erase,
    input  logic [WORD_W-1:0] op_word,
    input  logic              busy,
    input  logic              rd_strobe,
    input  logic [WORD_W-1:0] array_data,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_en
);
    op_ctx_t start_ctx;
    op_ctx_t eff_ctx;
    logic    eff_tog;
    word_t   resp_q;

    always_comb begin
        start_ctx.kind = op_kind_e'(op_erase);
        start_ctx.word = op_word;
    end

    fsr_op_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .start     (op_start),
        .start_ctx (start_ctx),
        .eff_ctx   (eff_ctx)
    );

    fsr_toggle u_toggle (
        .clk     (clk),
        .rst     (rst),
        .start   (op_start),
        .advance (rd_strobe && busy),
        .eff_tog (eff_tog)
    );

    fsr_resp u_resp (
        .clk        (clk),
        .rst        (rst),
        .rd         (rd_strobe),
        .busy       (busy),
        .eff_ctx    (eff_ctx),
        .eff_tog    (eff_tog),
        .array_data (array_data),
        .resp_q     (resp_q)
    );

    always_comb begin
        dq_en  = !ce_n && !oe_n;
        dq_out = dq_en ? resp_q : '0;
    end

    a_r1_float: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> (dq_out == '0 && !dq_en));
    a_r1_driven: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n) |-> dq_out == resp_q);
endmodule

// File: tb/flash_status_reporter_test.sv
`timescale 1ns/1ps
module flash_status_reporter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_start = 1'b0;
    logic        op_erase = 1'b0;
    logic [15:0] op_word = '0;
    logic        busy = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [15:0] array_data = '0;
    logic        ce_n = 1'b0;
    logic        oe_n = 1'b0;
    logic [15:0] dq_out;
    logic        dq_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        m_erase = 1'b0;
    logic [15:0] m_word = '0;
    logic        m_tog = 1'b0;
    logic [15:0] m_resp = '0;

    always #2 clk = ~clk;

    flash_status_reporter uut (
        .clk(clk), .rst(rst), .op_start(op_start), .op_erase(op_erase),
        .op_word(op_word), .busy(busy), .rd_strobe(rd_strobe),
        .array_data(array_data), .ce_n(ce_n), .oe_n(oe_n),
        .dq_out(dq_out), .dq_en(dq_en)
    );

    function automatic logic [15:0] model_busy(logic er, logic [15:0] w, logic t);
        logic [15:0] r;
        r = 16'h0000;
        r[15] = er ? 1'b0 : !w[15];
        r[7]  = er ? 1'b0 : !w[7];
        r[14] = t;
        r[6]  = t;
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic er, input logic [15:0] w,
                        input logic bz, input logic rd, input logic [15:0] ar,
                        input string req);
        @(negedge clk);
        op_start = st; op_erase = er; op_word = w;
        busy = bz; rd_strobe = rd; array_data = ar;
        if (st) begin m_erase = er; m_word = w; m_tog = 1'b0; end
        if (rd) begin
            m_resp = bz ? model_busy(m_erase, m_word, m_tog) : ar;
            if (bz) m_tog = !m_tog;
        end
        @(posedge clk); #1;
        op_start = 1'b0; rd_strobe = 1'b0;
        chk(req, dq_out, m_resp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R10 reset response", dq_out, 16'h0000);
        chk("R10 reset drive", {15'd0, dq_en}, 16'h0001);

        // Program of 0x0F70: bits 15 and 7 are 0, so polling reads 1.
        step(1, 0, 16'h0F70, 1, 0, 16'h0000, "R8 start no read");
        step(0, 0, 16'h0000, 1, 1, 16'hFFFF, "R8 first busy read");
        chk("R2 poll bits", dq_out & 16'h8080, 16'h8080);
        chk("R8 toggle clear", dq_out & 16'h4040, 16'h0000);
        step(0, 0, 16'h0000, 1, 1, 16'hFFFF, "R4 second read");
        chk("R4 lanes equal", {15'd0, dq_out[14]}, {15'd0, dq_out[6]});
        chk("R6 other bits zero", dq_out & ~16'hC0C0, 16'h0000);
        step(0, 0, 16'h0000, 1, 0, 16'h1111, "R5 idle");
        step(0, 0, 16'h0000, 1, 0, 16'h2222, "R5 idle");
        step(0, 0, 16'h0000, 1, 1, 16'h3333, "R5 toggle after idle");
        chk("R5 toggle back to 0", dq_out & 16'h4040, 16'h0000);

        // Program of 0x8000: bit 15 high, bit 7 low.
        step(1, 0, 16'h8000, 1, 0, 16'h0000, "R2 start");
        step(0, 0, 16'h0000, 1, 1, 16'h0000, "R2 mixed lanes");
        chk("R2 mixed poll", dq_out & 16'h8080, 16'h0080);

        step(0, 0, 16'h0000, 0, 1, 16'h1234, "R7 pass through");
        chk("R7 array value", dq_out, 16'h1234);

        // Erase started in the same cycle as a read.
        step(1, 1, 16'hFFFF, 1, 1, 16'hAAAA, "R9 start with read");
        chk("R9 new op toggle 0", dq_out, 16'h0000);
        step(0, 0, 16'h0000, 1, 1, 16'hAAAA, "R9 next read");
        chk("R3 erase poll zero", dq_out, 16'h4040);
        step(0, 0, 16'h0000, 0, 1, 16'hABCD, "R5 not-busy read");
        step(0, 0, 16'h0000, 1, 1, 16'h0000, "R5 toggle kept over idle read");
        chk("R5 toggle 0", dq_out, 16'h0000);

        // Output gating.
        @(negedge clk); oe_n = 1'b1; #1;
        chk("R1 oe high data", dq_out, 16'h0000);
        chk("R1 oe high en", {15'd0, dq_en}, 16'h0000);
        @(negedge clk); oe_n = 1'b0; ce_n = 1'b1; #1;
        chk("R1 ce high data", dq_out, 16'h0000);
        @(negedge clk); ce_n = 1'b0; #1;
        chk("R1 restored", dq_out, m_resp);

        // Random phase.
        begin
            int busy_left = 0;
            for (int i = 0; i < 600; i++) begin
                logic st, er, rd, bz;
                logic [15:0] w, ar;
                string req;
                st = ($urandom % 8) == 0;
                er = $urandom % 2;
                w  = $urandom;
                ar = $urandom;
                rd = ($urandom % 2) == 0;
                if (st) busy_left = 2 + ($urandom % 10);
                bz = (busy_left > 0);
                if (busy_left > 0) busy_left--;
                if (st && rd)      req = "R9 random";
                else if (rd && !bz) req = "R7 random";
                else if (rd && (st ? er : m_erase)) req = "R3 random";
                else if (rd)       req = "R2 random";
                else               req = "R5 random";
                step(st, er, w, bz, rd, ar, req);
                if ((i % 50) == 7) begin
                    @(negedge clk); oe_n = 1'b1; #1;
                    chk("R1 random mask", dq_out, 16'h0000);
                    @(negedge clk); oe_n = 1'b0; #1;
                    chk("R1 random unmask", dq_out, m_resp);
                end
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule